// File: doc/BRIEF.md
# Serial Byte Transmitter with Selectable Interrupt Triggers

This block turns a stream of bytes into an asynchronous serial line. Bytes arrive over a valid/ready input and wait in a four-slot queue. A shift register takes them one at a time. Each frame carries a low start bit, eight data bits with the least significant bit first, and a high stop bit. Every bit lasts sixteen pulses of an external baud tick. The rate generator is outside this block.

Software-style control pins set the behaviour. One pin enables the channel. One pin sets the idle polarity of the line. One pulse input requests a break. A 2-bit field chooses what raises the transmit interrupt: a byte entering the shifter, the queue draining to empty, or the end of all activity. The fourth code is reserved and stays silent. Clearing the enable throws away the frame in flight and everything queued.

Input handshake: a byte moves on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low when the queue is full or the channel is disabled. `in_valid` may be held while `in_ready` is low, and nothing is taken until `in_ready` rises.

Top module: `uart_tx_chan`

## Requirements
- R1: With `inv`=0, each frame sends a 0 start bit, eight data bits least significant bit first, and a 1 stop bit. Each bit lasts 16 `baud_tick` pulses. The line is 1 between frames.
- R2: Bytes accepted through the handshake leave the line in acceptance order, and each byte is sent exactly once.
- R3: The queue holds four bytes. `buf_full` is 1 while four bytes wait and `in_ready` is then 0. A byte offered while the queue is full is not taken and is never sent.
- R4: `tx_empty` is 1 exactly when the shifter is idle and the queue is empty. `tx_empty` is 1 after reset.
- R5: With `inv`=1 the line is the bitwise complement of the R1 waveform, so it idles at 0.
- R6: A `brk_set` pulse raises `brk_busy`. After the frame already in the shifter ends, and before any queued byte, the block sends 13 bit times of 0 (start plus twelve zeros) and then a 1 stop bit. `brk_busy` returns to 0 when that frame ends, and queued bytes follow it.
- R7: While `tx_en` is 0, the line sits at its idle level in the same cycle, `in_ready` is 0, and the frame in flight, the queue and any pending break are discarded. None of the discarded data is sent after the channel is re-enabled.
- R8: With `irq_mode`=2'b00, `irq` pulses once for each byte moved from the queue into the shifter.
- R9: With `irq_mode`=2'b10, `irq` pulses when a byte moved into the shifter leaves the queue empty. A byte written on that same edge keeps the queue non-empty, so no pulse is raised.
- R10: With `irq_mode`=2'b01, `irq` pulses once when a frame ends with the queue empty and no break pending.
- R11: With `irq_mode`=2'b11 no interrupt is raised. `irq` is never high for two cycles in a row. It goes high in the cycle after the edge on which its event takes effect.
- R12: After reset, `buf_full`, `brk_busy` and `irq` are 0, and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_en | input | 1 | Channel enable; 0 aborts and flushes |
| brk_set | input | 1 | Pulse that requests one break frame |
| inv | input | 1 | 1 inverts the line so it idles low |
| irq_mode | input | 2 | Interrupt trigger: 00 per load, 01 all done, 10 queue drained, 11 none |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Channel can take a byte this cycle |
| buf_full | output | 1 | Queue holds four bytes |
| tx_empty | output | 1 | Shifter idle and queue empty |
| brk_busy | output | 1 | Break request pending or in progress |
| irq | output | 1 | One-cycle interrupt pulse |
| txd | output | 1 | Serial output line |

## Verification
The assertions check, on every cycle, these relations:
- the queue count stays bounded and clears after a flush;
- a loaded frame starts low and every frame ends on a high stop bit;
- `tx_empty` and `buf_full` are never both high;
- the line is at its idle level while disabled;
- `irq` is a single-cycle pulse that never fires in the reserved mode;
- `brk_busy` drops once a break frame completes.

Other behaviours need whole scenarios, and only the bench's stimulus sequences show them:
- the decoded byte order on the line;
- the 208-cycle low span of a break and its place ahead of queued data;
- the exact interrupt counts per mode, including the R9 case where a concurrent write suppresses the drain pulse;
- the absence of leftover frames after an abort.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    IRQ_ON_LOAD  = 2'b00,
    IRQ_ON_DONE  = 2'b01,
    IRQ_ON_DRAIN = 2'b10,
    IRQ_NONE     = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: occupancy never exceeds the queue depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R7: a flush leaves the queue empty
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  // R2: the consumer never pops an empty queue
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int DATA_W = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int BRK_ZEROS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              baud_tick,
  input  logic              load_char,
  input  logic [DATA_W-1:0] char_data,
  input  logic              load_brk,
  output logic              busy,
  output logic              line_raw,
  output logic              done,
  output logic              done_brk
);
  localparam int FRAME_W = BRK_ZEROS + 2;
  localparam int NB_W    = $clog2(FRAME_W);
  localparam int SUB_W   = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  logic [FRAME_W-1:0] shreg;
  logic [NB_W-1:0]    bits_left;
  logic [SUB_W-1:0]   sub;
  logic               is_brk;
  logic               bit_end;

  assign bit_end  = busy && baud_tick && (sub == SUB_W'(TICKS_PER_BIT - 1));
  assign done     = bit_end && (bits_left == '0);
  assign done_brk = done && is_brk;
  assign line_raw = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      sub       <= '0;
      is_brk    <= 1'b0;
    end else if (abort) begin
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      sub       <= '0;
      is_brk    <= 1'b0;
    end else if (load_char) begin
      busy      <= 1'b1;
      shreg     <= {{(FRAME_W - DATA_W - 1){1'b1}}, char_data, 1'b0};
      bits_left <= NB_W'(DATA_W + 1);
      sub       <= '0;
      is_brk    <= 1'b0;
    end else if (load_brk) begin
      busy      <= 1'b1;
      shreg     <= {1'b1, {(FRAME_W - 1){1'b0}}};
      bits_left <= NB_W'(FRAME_W - 1);
      sub       <= '0;
      is_brk    <= 1'b1;
    end else if (busy && baud_tick) begin
      if (bit_end) begin
        sub <= '0;
        if (bits_left == '0) begin
          busy   <= 1'b0;
          is_brk <= 1'b0;
        end else begin
          shreg     <= {1'b1, shreg[FRAME_W-1:1]};
          bits_left <= bits_left - 1'b1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  // R1: a freshly loaded frame begins with a low start bit
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_char && !abort) |=> (busy && !line_raw));
  // R1: every frame, data or break, ends on a high stop bit
  p_stop_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> line_raw);
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       load_evt,
  input  logic       drain_evt,
  input  logic       done_evt,
  output logic       irq
);
  irq_mode_e m;
  logic      hit;

  assign m = irq_mode_e'(mode);

  always_comb begin
    case (m)
      IRQ_ON_LOAD:  hit = load_evt;
      IRQ_ON_DONE:  hit = done_evt;
      IRQ_ON_DRAIN: hit = drain_evt;
      default:      hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= en && hit;
  end

  // R11: the reserved code never raises an interrupt
  p_reserved_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(mode) != 2'b11));
  // R11: the interrupt is a single-cycle pulse
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TICKS_PER_BIT = 16,
  parameter int BRK_ZEROS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              brk_set,
  input  logic              inv,
  input  logic [1:0]        irq_mode,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              buf_full,
  output logic              tx_empty,
  output logic              brk_busy,
  output logic              irq,
  output logic              txd
);
  localparam int CW = $clog2(DEPTH + 1);

  logic              push, pop, q_empty;
  logic [DATA_W-1:0] q_data;
  logic [CW-1:0]     q_count;
  logic              busy, line_raw, done, done_brk;
  logic              load_char, load_brk, can_load;
  logic              drain_evt, done_evt;
  logic              brk_bit;

  assign in_ready = tx_en && !buf_full;
  assign push     = in_valid && in_ready;

  // Break has priority over queued data once the shifter is free.
  assign can_load  = tx_en && !busy;
  assign load_brk  = can_load && brk_bit;
  assign load_char = can_load && !brk_bit && !q_empty;
  assign pop       = load_char;

  assign drain_evt = load_char && (q_count == CW'(1)) && !push;
  assign done_evt  = done && q_empty && !push && (!brk_bit || done_brk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        brk_bit <= 1'b0;
    else if (!tx_en)   brk_bit <= 1'b0;
    else if (done_brk) brk_bit <= 1'b0;
    else if (brk_set)  brk_bit <= 1'b1;
  end

  uart_tx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!tx_en), .push(push), .wdata(in_data),
    .pop(pop), .rdata(q_data), .count(q_count), .full(buf_full), .empty(q_empty)
  );

  uart_tx_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT),
                    .BRK_ZEROS(BRK_ZEROS)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(!tx_en), .baud_tick(baud_tick),
    .load_char(load_char), .char_data(q_data), .load_brk(load_brk),
    .busy(busy), .line_raw(line_raw), .done(done), .done_brk(done_brk)
  );

  uart_tx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .mode(irq_mode),
    .load_evt(load_char), .drain_evt(drain_evt), .done_evt(done_evt), .irq(irq)
  );

  assign tx_empty = !busy && q_empty;
  assign brk_busy = brk_bit;
  assign txd      = tx_en ? (line_raw ^ inv) : !inv;

  // R4: an empty channel cannot report a full queue
  p_empty_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> !buf_full);
  // R7: a disabled channel holds the line at its idle level
  p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (txd == !inv));
  // R6: a finished break frame drops the break request
  p_brk_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_brk |=> !brk_busy);
endmodule

// File: tb/tb_uart_tx_chan.sv
module tb_uart_tx_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       tx_en = 1'b0;
  logic       brk_set = 1'b0;
  logic       inv = 1'b0;
  logic [1:0] irq_mode = 2'b00;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, buf_full, tx_empty, brk_busy, irq, txd;

  int         checks = 0;
  int         fails = 0;
  logic [8:0] exp_q[$];
  bit         mon_en = 1'b1;
  int         irq_cnt = 0;
  int         base;
  int         stray;
  logic [7:0] mon_d;
  logic       mon_stop;
  logic [8:0] mon_item;
  logic [8:0] mon_exp;
  int         mon_low;

  uart_tx_chan dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .brk_set(brk_set), .inv(inv), .irq_mode(irq_mode), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .buf_full(buf_full),
    .tx_empty(tx_empty), .brk_busy(brk_busy), .irq(irq), .txd(txd)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Driver: called at a negedge, returns at a negedge after the byte is taken.
  task automatic put(input logic [7:0] b, input bit rec);
    bit ok;
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
    if (rec) exp_q.push_back({1'b0, b});
  endtask

  task automatic brk_pulse(input bit rec);
    brk_set = 1'b1;
    @(negedge clk);
    brk_set = 1'b0;
    if (rec) exp_q.push_back({1'b1, 8'h00});
  endtask

  task automatic wait_idle();
    while (!tx_empty) @(negedge clk);
    repeat (24) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "frames still expected", exp_q.size(), 0);
  endtask

  always @(negedge clk) if (irq) irq_cnt++;

  // Monitor: decodes the line independently and compares with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && ((txd ^ inv) == 1'b0)) begin
        repeat (7) @(negedge clk);
        chk((txd ^ inv) == 1'b0, "R1", "start bit level", txd ^ inv, 0);
        for (int k = 0; k < 8; k++) begin
          repeat (16) @(negedge clk);
          mon_d[k] = txd ^ inv;
        end
        repeat (16) @(negedge clk);
        mon_stop = txd ^ inv;
        if (mon_stop) begin
          mon_item = {1'b0, mon_d};
        end else begin
          mon_low = 152;
          forever begin
            @(negedge clk);
            if ((txd ^ inv) != 1'b0) break;
            mon_low++;
          end
          chk(mon_low == 208, "R6", "break low span", mon_low, 208);
          mon_item = {1'b1, mon_d};
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected frame", mon_item, 0);
        end else begin
          mon_exp = exp_q.pop_front();
          chk(mon_item == mon_exp, mon_exp[8] ? "R6" : "R1", "frame content",
              mon_item, mon_exp);
        end
      end
    end
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_empty == 1'b1, "R4", "tx_empty at reset", tx_empty, 1);
    chk(buf_full == 1'b0, "R12", "buf_full at reset", buf_full, 0);
    chk(irq == 1'b0, "R12", "irq at reset", irq, 0);
    chk(brk_busy == 1'b0, "R12", "brk_busy at reset", brk_busy, 0);
    chk(txd == 1'b1, "R12", "txd at reset", txd, 1);
    chk(in_ready == 1'b0, "R7", "in_ready while disabled", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: one pulse per byte loaded into the shifter
    tx_en = 1'b1;
    irq_mode = 2'b00;
    @(negedge clk);
    base = irq_cnt;
    put(8'hA5, 1); put(8'h3C, 1); put(8'h01, 1);
    chk(tx_empty == 1'b0, "R4", "tx_empty while busy", tx_empty, 0);
    wait_idle();
    chk(irq_cnt - base == 3, "R8", "irq count load mode", irq_cnt - base, 3);
    chk(tx_empty == 1'b1, "R4", "tx_empty after drain", tx_empty, 1);

    // R9: back-to-back writes suppress the first drain pulse
    irq_mode = 2'b10;
    base = irq_cnt;
    put(8'hFF, 1); put(8'h00, 1); put(8'h5A, 1);
    wait_idle();
    chk(irq_cnt - base == 1, "R9", "irq count drain mode x3", irq_cnt - base, 1);
    base = irq_cnt;
    put(8'h81, 1);
    wait_idle();
    chk(irq_cnt - base == 1, "R9", "irq count drain mode x1", irq_cnt - base, 1);

    // R10: a single pulse once all activity ends
    irq_mode = 2'b01;
    base = irq_cnt;
    put(8'h12, 1); put(8'h34, 1); put(8'h56, 1);
    repeat (200) @(negedge clk);
    chk(irq_cnt - base == 0, "R10", "no irq mid stream", irq_cnt - base, 0);
    wait_idle();
    chk(irq_cnt - base == 1, "R10", "irq count done mode", irq_cnt - base, 1);

    // R11: reserved mode stays silent
    irq_mode = 2'b11;
    base = irq_cnt;
    put(8'hC0, 1); put(8'h0C, 1);
    wait_idle();
    chk(irq_cnt - base == 0, "R11", "irq count reserved mode", irq_cnt - base, 0);

    // R3: full queue refuses further bytes
    put(8'h11, 1); put(8'h22, 1); put(8'h33, 1); put(8'h44, 1); put(8'h55, 1);
    chk(buf_full == 1'b1, "R3", "buf_full with four queued", buf_full, 1);
    chk(in_ready == 1'b0, "R3", "in_ready when full", in_ready, 0);
    in_valid = 1'b1;
    in_data = 8'hEE;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(buf_full == 1'b1, "R3", "buf_full after refused offer", buf_full, 1);
    wait_idle();
    chk(buf_full == 1'b0, "R3", "buf_full after drain", buf_full, 0);

    // R6: break after the current byte, before the queued one
    irq_mode = 2'b00;
    base = irq_cnt;
    put(8'h81, 1);
    brk_pulse(1);
    chk(brk_busy == 1'b1, "R6", "brk_busy after request", brk_busy, 1);
    put(8'h7E, 1);
    wait_idle();
    chk(brk_busy == 1'b0, "R6", "brk_busy after break frame", brk_busy, 0);
    chk(irq_cnt - base == 2, "R8", "break frame not counted", irq_cnt - base, 2);

    // R5: inverted line
    inv = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R5", "inverted idle level", txd, 0);
    put(8'hC3, 1); put(8'h0F, 1);
    wait_idle();
    chk(txd == 1'b0, "R5", "inverted idle after frames", txd, 0);
    inv = 1'b0;
    @(negedge clk);

    // R7: disable aborts, flushes, and clears a pending break
    mon_en = 1'b0;
    put(8'hAA, 0); put(8'hBB, 0); put(8'hCC, 0);
    brk_pulse(0);
    repeat (40) @(negedge clk);
    tx_en = 1'b0;
    #0;
    chk(txd == 1'b1, "R7", "line idle at once", txd, 1);
    @(negedge clk);
    chk(tx_empty == 1'b1, "R7", "tx_empty after abort", tx_empty, 1);
    chk(buf_full == 1'b0, "R7", "queue flushed", buf_full, 0);
    chk(brk_busy == 1'b0, "R7", "break cleared", brk_busy, 0);
    chk(in_ready == 1'b0, "R7", "in_ready while disabled", in_ready, 0);
    repeat (10) @(negedge clk);
    tx_en = 1'b1;
    stray = 0;
    repeat (300) begin
      @(negedge clk);
      if (txd != 1'b1) stray++;
    end
    chk(stray == 0, "R7", "cycles of leftover activity", stray, 0);
    mon_en = 1'b1;
    put(8'h96, 1);
    wait_idle();

    summary();
    $finish;
  end
endmodule